// File: doc/BRIEF.md
# Victim Buffer for a Decoded-Instruction Cache

This block is a small, fully associative store that catches lines pushed out of a large direct-mapped cache of decoded instructions. When the main cache misses, the fetch logic presents the physical address and the current fetch-mode tag here. If some entry carries both the same address and the same mode, its payload is returned in the same cycle. The caller then reuses that payload and does not rebuild it.

If no entry hits, the caller hands in the line being displaced from the main cache. That line is written into the slot named by a rotating insertion pointer, and the pointer then steps forward, wrapping at the entry count. A displaced line that was never valid is dropped. Entries carry no separate valid bit: an address field holding the reserved all-ones value marks the entry empty.

Two events clear the store. A flush empties every slot and returns the pointer to slot 0. A code-write notice empties every slot but leaves the pointer where it was. The payload is an opaque vector whose width is set by a parameter.

Top module: `victim_buf`

## Requirements
- R1: `lk_hit` is 1 in the same cycle as the request only when some entry holds an address equal to `lk_addr` and a mode equal to `lk_mode`. A match on address alone, or on mode alone, does not hit.
- R2: On a hit, `lk_data` is the payload stored with the matching entry. On a miss, `lk_data` is all zeros.
- R3: A valid insert (`ins_en`=1 with `ins_addr` not all ones) writes address, mode and payload into the slot at the insertion pointer on the next clock edge. The pointer then advances by one modulo ENTRIES, so the ENTRIES+1-th insert after a flush overwrites the oldest line.
- R4: An insert whose `ins_addr` is all ones (the reserved empty marker) changes no entry and does not move the pointer.
- R5: `flush`=1 empties every entry and sets the pointer to slot 0 on the next edge.
- R6: `code_wr`=1 empties every entry on the next edge, whatever the address, and keeps the pointer unchanged.
- R7: A `flush` or `code_wr` in the same cycle as an insert wins, and the insert is dropped.
- R8: Synchronous `rst` acts exactly like a flush.
- R9: When several entries match a request, the payload of the lowest-index matching entry is returned.
- R10: A lookup in the same cycle as an insert sees the contents from before that insert.
- R11: A request with `lk_addr` all ones never hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high, same effect as a flush |
| flush | input | 1 | Empty all entries and return the pointer to slot 0 |
| code_wr | input | 1 | Code-write notice: empty all entries, keep the pointer |
| lk_addr | input | ADDR_W | Lookup physical address |
| lk_mode | input | MODE_W | Lookup fetch-mode tag |
| lk_hit | output | 1 | Lookup hit, combinational |
| lk_data | output | DATA_W | Payload of the lowest-index matching entry, zero on a miss |
| ins_en | input | 1 | Insert the displaced line |
| ins_addr | input | ADDR_W | Address of the displaced line (all ones means the line is empty) |
| ins_mode | input | MODE_W | Fetch-mode tag stored with the displaced line |
| ins_data | input | DATA_W | Payload of the displaced line |

## Verification
The insertion pointer cannot be seen at the ports. The hardest case is showing that a code-write notice leaves it in place while a flush resets it. The stimulus fills part of the store, issues the notice, then inserts the same address and mode twice with different payloads, separated by enough fillers that the second copy wraps to a lower slot than the first. Under the lowest-index rule, the payload that comes back shows where the pointer stood. Random traffic over a small pool of addresses and two modes produces duplicate entries, wraps and collisions between inserts and clears, and a bench model follows them.

// File: rtl/vb_pkg.sv
package vb_pkg;

    typedef enum logic [1:0] {
        VB_HOLD  = 2'd0,
        VB_PUSH  = 2'd1,
        VB_CLEAR = 2'd2,
        VB_WIPE  = 2'd3
    } vb_op_e;

    // Clears beat inserts; reset is a flush.
    function automatic vb_op_e vb_decode(input logic rst,
                                         input logic flush,
                                         input logic code_wr,
                                         input logic push_ok);
        vb_op_e op;
        if (rst || flush)  op = VB_CLEAR;
        else if (code_wr)  op = VB_WIPE;
        else if (push_ok)  op = VB_PUSH;
        else               op = VB_HOLD;
        return op;
    endfunction

endpackage

// File: rtl/vb_match.sv
module vb_match #(
    parameter int N      = 8,
    parameter int ADDR_W = 32,
    parameter int MODE_W = 8
) (
    input  logic [N-1:0][ADDR_W-1:0] ent_addr,
    input  logic [N-1:0][MODE_W-1:0] ent_mode,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [MODE_W-1:0]        req_mode,
    output logic [N-1:0]             hit_vec
);
    localparam logic [ADDR_W-1:0] EMPTY = '1;

    logic req_ok;
    assign req_ok = (req_addr != EMPTY);

    for (genvar g = 0; g < N; g++) begin : g_cmp
        logic live;
        assign live       = (ent_addr[g] != EMPTY);
        assign hit_vec[g] = req_ok && live &&
                            (ent_addr[g] == req_addr) &&
                            (ent_mode[g] == req_mode);
    end
endmodule

// File: rtl/vb_pick.sv
module vb_pick #(
    parameter int N    = 8,
    parameter int IDXW = 3
) (
    input  logic [N-1:0]    req,
    output logic            any,
    output logic [IDXW-1:0] idx,
    output logic [N-1:0]    onehot
);
    always_comb begin
        idx    = '0;
        onehot = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (req[k]) begin
                idx    = IDXW'(k);
                onehot = '0;
                onehot[k] = 1'b1;
            end
        end
        any = |req;
    end
endmodule

// File: rtl/victim_buf.sv
module victim_buf #(
    parameter int ENTRIES = 8,
    parameter int ADDR_W  = 32,
    parameter int MODE_W  = 8,
    parameter int DATA_W  = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              code_wr,
    input  logic [ADDR_W-1:0] lk_addr,
    input  logic [MODE_W-1:0] lk_mode,
    output logic              lk_hit,
    output logic [DATA_W-1:0] lk_data,
    input  logic              ins_en,
    input  logic [ADDR_W-1:0] ins_addr,
    input  logic [MODE_W-1:0] ins_mode,
    input  logic [DATA_W-1:0] ins_data
);
    import vb_pkg::*;

    localparam int PW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [ADDR_W-1:0] EMPTY = '1;

    typedef struct packed {
        logic [ENTRIES-1:0][ADDR_W-1:0] addr;
        logic [ENTRIES-1:0][MODE_W-1:0] mode;
        logic [ENTRIES-1:0][DATA_W-1:0] data;
        logic [PW-1:0]                  ptr;
    } vb_state_t;

    vb_state_t st_d, st_q;

    logic [ENTRIES-1:0] hit_vec;
    logic [ENTRIES-1:0] sel_oh;
    logic [PW-1:0]      sel_idx;
    logic               sel_any;
    logic               push_ok;
    vb_op_e             op;

    vb_match #(
        .N      (ENTRIES),
        .ADDR_W (ADDR_W),
        .MODE_W (MODE_W)
    ) u_match (
        .ent_addr (st_q.addr),
        .ent_mode (st_q.mode),
        .req_addr (lk_addr),
        .req_mode (lk_mode),
        .hit_vec  (hit_vec)
    );

    vb_pick #(
        .N    (ENTRIES),
        .IDXW (PW)
    ) u_pick (
        .req    (hit_vec),
        .any    (sel_any),
        .idx    (sel_idx),
        .onehot (sel_oh)
    );

    assign lk_hit  = sel_any;
    assign lk_data = sel_any ? st_q.data[sel_idx] : '0;

    assign push_ok = ins_en && (ins_addr != EMPTY);
    assign op      = vb_decode(rst, flush, code_wr, push_ok);

    always_comb begin
        st_d = st_q;
        unique case (op)
            VB_CLEAR: begin
                for (int e = 0; e < ENTRIES; e++) st_d.addr[e] = EMPTY;
                st_d.ptr = '0;
            end
            VB_WIPE: begin
                for (int e = 0; e < ENTRIES; e++) st_d.addr[e] = EMPTY;
            end
            VB_PUSH: begin
                st_d.addr[st_q.ptr] = ins_addr;
                st_d.mode[st_q.ptr] = ins_mode;
                st_d.data[st_q.ptr] = ins_data;
                st_d.ptr            = st_q.ptr + PW'(1);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

endmodule

// File: rtl/vb_chk.sv
module vb_chk #(
    parameter int ENTRIES = 8,
    parameter int ADDR_W  = 32,
    parameter int PW      = 3
) (
    input logic               clk,
    input logic               rst,
    input logic               flush,
    input logic               code_wr,
    input logic               ins_en,
    input logic [ADDR_W-1:0]  ins_addr,
    input logic [ADDR_W-1:0]  lk_addr,
    input logic               lk_hit,
    input logic [PW-1:0]      ptr_q,
    input logic [ENTRIES-1:0] sel_oh
);
    localparam logic [ADDR_W-1:0] EMPTY = '1;

    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        (flush || code_wr) |=> !lk_hit); // R7

    AST_FLUSH_PTR_ZERO: assert property (@(posedge clk) disable iff (rst)
        flush |=> (ptr_q == '0)); // R5

    AST_CODE_WR_KEEPS_PTR: assert property (@(posedge clk) disable iff (rst)
        (code_wr && !flush) |=> $stable(ptr_q)); // R6

    AST_EMPTY_INSERT_NO_MOVE: assert property (@(posedge clk) disable iff (rst)
        (ins_en && ins_addr == EMPTY && !flush && !code_wr) |=> $stable(ptr_q)); // R4

    AST_IDLE_NO_MOVE: assert property (@(posedge clk) disable iff (rst)
        (!ins_en && !flush && !code_wr) |=> $stable(ptr_q)); // R3

    AST_RESERVED_NEVER_HITS: assert property (@(posedge clk) disable iff (rst)
        (lk_addr == EMPTY) |-> !lk_hit); // R11

    AST_SINGLE_SELECT: assert property (@(posedge clk) disable iff (rst)
        lk_hit |-> $onehot(sel_oh)); // R9

    AST_MISS_NO_SELECT: assert property (@(posedge clk) disable iff (rst)
        !lk_hit |-> (sel_oh == '0)); // R1
endmodule

bind victim_buf vb_chk #(
    .ENTRIES (ENTRIES),
    .ADDR_W  (ADDR_W),
    .PW      (PW)
) u_vb_chk (
    .clk      (clk),
    .rst      (rst),
    .flush    (flush),
    .code_wr  (code_wr),
    .ins_en   (ins_en),
    .ins_addr (ins_addr),
    .lk_addr  (lk_addr),
    .lk_hit   (lk_hit),
    .ptr_q    (st_q.ptr),
    .sel_oh   (sel_oh)
);

// File: tb/test_victim_buf.sv
`timescale 1ns/1ps
module test_victim_buf;
    localparam int N  = 8;
    localparam int AW = 32;
    localparam int MW = 8;
    localparam int DW = 64;
    localparam logic [AW-1:0] EMPTY = '1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          flush = 1'b0, code_wr = 1'b0, ins_en = 1'b0;
    logic [AW-1:0] lk_addr = '0, ins_addr = '0;
    logic [MW-1:0] lk_mode = '0, ins_mode = '0;
    logic [DW-1:0] ins_data = '0;
    logic          lk_hit;
    logic [DW-1:0] lk_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [AW-1:0] m_addr [N];
    logic [MW-1:0] m_mode [N];
    logic [DW-1:0] m_data [N];
    int            m_ptr;

    always #5 clk = ~clk;

    victim_buf #(.ENTRIES(N), .ADDR_W(AW), .MODE_W(MW), .DATA_W(DW)) i_victim_buf (
        .clk(clk), .rst(rst), .flush(flush), .code_wr(code_wr),
        .lk_addr(lk_addr), .lk_mode(lk_mode), .lk_hit(lk_hit), .lk_data(lk_data),
        .ins_en(ins_en), .ins_addr(ins_addr), .ins_mode(ins_mode), .ins_data(ins_data)
    );

    function automatic int exp_slot(input logic [AW-1:0] a, input logic [MW-1:0] m);
        if (a == EMPTY) return -1;
        for (int k = 0; k < N; k++)
            if (m_addr[k] == a && m_mode[k] == m) return k;
        return -1;
    endfunction

    function automatic void model_clear(input bit reset_ptr);
        for (int k = 0; k < N; k++) m_addr[k] = EMPTY;
        if (reset_ptr) m_ptr = 0;
    endfunction

    task automatic step(input logic [AW-1:0] la, input logic [MW-1:0] lm,
                        input bit ie, input logic [AW-1:0] ia, input logic [MW-1:0] im,
                        input logic [DW-1:0] idat, input bit fl, input bit cw,
                        input string tag);
        int s;
        logic          eh;
        logic [DW-1:0] ed;
        @(negedge clk);
        lk_addr = la; lk_mode = lm;
        ins_en = ie; ins_addr = ia; ins_mode = im; ins_data = idat;
        flush = fl; code_wr = cw;
        #1;
        s  = exp_slot(la, lm);
        eh = (s >= 0);
        ed = eh ? m_data[s] : '0;
        checks++;
        if (lk_hit !== eh || lk_data !== ed) begin
            errors++;
            $display("FAIL %s addr=%h mode=%h hit=%b data=%h expected hit=%b data=%h",
                     tag, la, lm, lk_hit, lk_data, eh, ed);
        end
        if (fl) model_clear(1);
        else if (cw) model_clear(0);
        else if (ie && ia != EMPTY) begin
            m_addr[m_ptr] = ia; m_mode[m_ptr] = im; m_data[m_ptr] = idat;
            m_ptr = (m_ptr + 1) % N;
        end
    endtask

    task automatic look(input logic [AW-1:0] a, input logic [MW-1:0] m, input string tag);
        step(a, m, 1'b0, '0, '0, '0, 1'b0, 1'b0, tag);
    endtask

    task automatic put(input logic [AW-1:0] a, input logic [MW-1:0] m,
                       input logic [DW-1:0] d, input string tag);
        step(32'h0BAD_0000, 8'hEE, 1'b1, a, m, d, 1'b0, 1'b0, tag);
    endtask

    task automatic do_flush(input string tag);
        step(32'h0BAD_0000, 8'hEE, 1'b0, '0, '0, '0, 1'b1, 1'b0, tag);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int unsigned r;
        r = $urandom(32'd20240611);
        model_clear(1);
        repeat (3) @(negedge clk);
        // Reset with a valid insert pending: R8 says it is dropped.
        ins_en = 1'b1; ins_addr = 32'h100; ins_mode = 8'h1; ins_data = 64'hAA;
        @(negedge clk);
        rst = 1'b0; ins_en = 1'b0;
        look(32'h100, 8'h1, "R8");
        look(32'h0,   8'h0, "R8");

        // R1 / R2
        put(32'h100, 8'h1, 64'h1111, "R3");
        look(32'h100, 8'h1, "R1 R2");
        look(32'h100, 8'h2, "R1");
        look(32'h104, 8'h1, "R1");

        // R10: lookup and insert of the same line in one cycle
        step(32'h200, 8'h1, 1'b1, 32'h200, 8'h1, 64'h2222, 1'b0, 1'b0, "R10");
        look(32'h200, 8'h1, "R10");

        // R4 and R11
        put(EMPTY, 8'h1, 64'hDEAD, "R4");
        look(EMPTY, 8'h1, "R11");
        put(32'h300, 8'h1, 64'h3333, "R4");
        look(32'h300, 8'h1, "R4");

        // R5 / R3 wrap
        do_flush("R5");
        look(32'h100, 8'h1, "R5");
        for (int k = 0; k <= N; k++) put(32'h1000 + k * 4, 8'h3, 64'h5000 + k, "R3");
        look(32'h1000, 8'h3, "R3");
        look(32'h1004, 8'h3, "R3");
        look(32'h1000 + N * 4, 8'h3, "R3");

        // R9 duplicates
        do_flush("R5");
        put(32'h400, 8'h2, 64'hA1, "R9");
        put(32'h400, 8'h2, 64'hA2, "R9");
        look(32'h400, 8'h2, "R9");

        // R6 pointer retained across code write
        do_flush("R5");
        for (int k = 0; k < 3; k++) put(32'h600 + k * 4, 8'h1, 64'h60 + k, "R6");
        step(32'h600, 8'h1, 1'b0, '0, '0, '0, 1'b0, 1'b1, "R6");
        look(32'h600, 8'h1, "R6");
        put(32'h700, 8'h4, 64'hD1, "R6");
        for (int k = 0; k < 5; k++) put(32'h800 + k * 4, 8'h1, 64'h80 + k, "R6");
        put(32'h700, 8'h4, 64'hD2, "R6");
        look(32'h700, 8'h4, "R6");

        // R7 clears beat inserts
        step(32'h0, 8'h0, 1'b1, 32'h900, 8'h1, 64'h9, 1'b1, 1'b0, "R7");
        look(32'h900, 8'h1, "R7");
        step(32'h0, 8'h0, 1'b1, 32'h904, 8'h1, 64'h9, 1'b0, 1'b1, "R7");
        look(32'h904, 8'h1, "R7");

        // Random traffic
        for (int t = 0; t < 4000; t++) begin
            logic [AW-1:0] la, ia;
            logic [MW-1:0] lm, im;
            bit ie, fl, cw;
            la = 32'h2000 + ($urandom % 12) * 4;
            if ($urandom % 20 == 0) la = EMPTY;
            lm = 8'($urandom % 2);
            ia = 32'h2000 + ($urandom % 12) * 4;
            if ($urandom % 10 == 0) ia = EMPTY;
            im = 8'($urandom % 2);
            ie = ($urandom % 3) != 0;
            fl = ($urandom % 60) == 0;
            cw = ($urandom % 45) == 0;
            step(la, lm, ie, ia, im, {$urandom, $urandom}, fl, cw, "R2");
        end

        // Mid-run reset, R8
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        model_clear(1);
        for (int k = 0; k < 4; k++) look(32'h2000 + k * 4, 8'h0, "R8");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule